// File: doc/BRIEF.md
# Security State Machine Controller

This block holds the security posture of a chip as a five-state machine: check, trusted, secure, soft-fail and non-secure. Software moves it by writing one-shot command bits over a small memory-mapped register bus. It can request an orderly step, raise a security violation, or raise a fatal violation. Two hardware pins raise the same violations directly. The current state is always visible in a status field and on a dedicated output.

Two sticky configuration bits let software close individual paths ahead of time. One blocks the return from secure to trusted. The other blocks the escape from soft-fail to non-secure. Once soft-fail or non-secure is reached, no command can lead back to trusted.

The block also keeps a word of retention data. Software can write the whole word, or set or clear one bit by index. A violation wipes this word to zero unless a zeroize-disable control bit is set.

Register map (word addresses): 0 command, 1 status, 2 low-power control, 3 retention word, 4 retention bit-set, 5 retention bit-clear. State codes in status bits [3:0]: check = 1, trusted = 2, secure = 3, soft-fail = 4, non-secure = 5.

Top module: `sec_state_ctrl`

## Requirements
- R1: After reset the state is check (code 1), both disable bits and the zeroize-disable bit are 0, and the retention word is 0.
- R2: A step request (command bit 0) moves check to trusted and trusted to secure.
- R3: A step request in secure moves to trusted only while the secure-to-trusted disable (command bit 3) is 0; otherwise the state stays secure.
- R4: A step request in soft-fail moves to non-secure only while the soft-fail-to-non-secure disable (command bit 4) is 0. Non-secure ignores step requests.
- R5: A violation (command bit 1 or pin viol_i high) moves check to non-secure, and moves trusted, secure or soft-fail to soft-fail. Non-secure stays non-secure.
- R6: A fatal violation (command bit 2 or pin fatal_i high) moves every state except non-secure to soft-fail. In one cycle, fatal outranks violation, and violation outranks step.
- R7: No sequence of requests leads from soft-fail or non-secure back to trusted.
- R8: Command bits 2:0 are one-shot: they read back as 0, and one write makes exactly one move. With no request, the state holds.
- R9: The disable bits (command bits 3 and 4) are set by writing 1, and only reset clears them. Writing 0 leaves them set. They read back at the same bit positions.
- R10: The retention word is read and written whole at address 3. Writing index n (wdata bits 4:0) to address 4 sets bit n, and writing it to address 5 clears bit n. Addresses 4 to 7 read as 0.
- R11: A violation or fatal violation clears the retention word to 0 when the zeroize-disable bit (low-power control bit 0) is 0, and leaves it unchanged when that bit is 1.
- R12: A request sampled at clock edge k changes the state at edge k+1. Read data appears on the edge after rd_en is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| viol_i | input | 1 | Hardware security violation, level sampled each cycle |
| fatal_i | input | 1 | Hardware fatal violation, level sampled each cycle |
| rdata | output | DATA_W | Registered read data |
| state_o | output | 4 | Current state code |

## Verification
The bench sweeps every start state against every kind of request, under all eight settings of the two disable bits and the zeroize-disable bit. The requests are a step, a written violation, a written fatal, a violation pin, a fatal pin, step plus violation, violation plus fatal, and no request at all. This tells apart the priority order, the blocking effect of each disable bit, and the difference between a violation in check (to non-secure) and elsewhere (to soft-fail). It also shows whether the retention word is wiped or kept in each case. Directed runs cover the reset values, the bit-indexed set and clear, the stickiness of the disable bits, and the one-edge delay from a request to the state change.

// File: rtl/sec_state_pkg.sv
package sec_state_pkg;

  typedef enum logic [3:0] {
    ST_CHECK    = 4'h1,
    ST_TRUST    = 4'h2,
    ST_SECURE   = 4'h3,
    ST_SOFTFAIL = 4'h4,
    ST_NONSEC   = 4'h5
  } sec_st_e;

  typedef struct packed {
    logic go;
    logic viol;
    logic fatal;
  } sec_req_t;

  // Word addresses
  localparam int unsigned A_CMD   = 0;
  localparam int unsigned A_STAT  = 1;
  localparam int unsigned A_LPCTL = 2;
  localparam int unsigned A_RET   = 3;
  localparam int unsigned A_RSET  = 4;
  localparam int unsigned A_RCLR  = 5;

  // Command register bit positions
  localparam int unsigned B_GO    = 0;
  localparam int unsigned B_VIOL  = 1;
  localparam int unsigned B_FATAL = 2;
  localparam int unsigned B_DST   = 3;
  localparam int unsigned B_DSF   = 4;

  // Low-power control bit position
  localparam int unsigned B_ZDIS  = 0;

  // Next-state rule: fatal over violation over step
  function automatic sec_st_e sec_next(sec_st_e cur, sec_req_t r,
                                       logic dis_st, logic dis_sfns);
    sec_st_e nxt;
    nxt = cur;
    if (r.fatal) begin
      nxt = (cur == ST_NONSEC) ? ST_NONSEC : ST_SOFTFAIL;
    end else if (r.viol) begin
      case (cur)
        ST_CHECK:                          nxt = ST_NONSEC;
        ST_TRUST, ST_SECURE, ST_SOFTFAIL:  nxt = ST_SOFTFAIL;
        default:                           nxt = cur;
      endcase
    end else if (r.go) begin
      case (cur)
        ST_CHECK:    nxt = ST_TRUST;
        ST_TRUST:    nxt = ST_SECURE;
        ST_SECURE:   nxt = dis_st ? ST_SECURE : ST_TRUST;
        ST_SOFTFAIL: nxt = dis_sfns ? ST_SOFTFAIL : ST_NONSEC;
        default:     nxt = cur;
      endcase
    end
    return nxt;
  endfunction

  function automatic logic sec_is_violation(sec_req_t r);
    return r.viol | r.fatal;
  endfunction

endpackage

// File: rtl/sec_regs.sv
module sec_regs
  import sec_state_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              viol_i,
  input  logic              fatal_i,
  input  sec_st_e           state_i,
  input  logic [DATA_W-1:0] ret_i,
  output logic [DATA_W-1:0] rdata,
  output sec_req_t          req_o,
  output logic              dis_st_o,
  output logic              dis_sfns_o,
  output logic              zdis_o,
  output logic              ret_we_o,
  output logic              ret_set_o,
  output logic              ret_clr_o,
  output logic [IDX_W-1:0]  ret_idx_o,
  output logic [DATA_W-1:0] ret_wdata_o
);

  logic wr_cmd, wr_lpc;
  logic go_wr, viol_wr, fatal_wr;
  logic [DATA_W-1:0] rd_mux;

  assign wr_cmd   = wr_en && (addr == ADDR_W'(A_CMD));
  assign wr_lpc   = wr_en && (addr == ADDR_W'(A_LPCTL));
  assign go_wr    = wr_cmd && wdata[B_GO];
  assign viol_wr  = wr_cmd && wdata[B_VIOL];
  assign fatal_wr = wr_cmd && wdata[B_FATAL];

  assign ret_we_o    = wr_en && (addr == ADDR_W'(A_RET));
  assign ret_set_o   = wr_en && (addr == ADDR_W'(A_RSET));
  assign ret_clr_o   = wr_en && (addr == ADDR_W'(A_RCLR));
  assign ret_idx_o   = wdata[IDX_W-1:0];
  assign ret_wdata_o = wdata;

  // One-shot request register: each bit lives for exactly one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o <= '0;
    end else begin
      req_o.go    <= go_wr;
      req_o.viol  <= viol_wr | viol_i;
      req_o.fatal <= fatal_wr | fatal_i;
    end
  end

  // Sticky disables, plain zeroize-disable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_st_o   <= 1'b0;
      dis_sfns_o <= 1'b0;
      zdis_o     <= 1'b0;
    end else begin
      if (wr_cmd && wdata[B_DST]) dis_st_o   <= 1'b1;
      if (wr_cmd && wdata[B_DSF]) dis_sfns_o <= 1'b1;
      if (wr_lpc)                 zdis_o     <= wdata[B_ZDIS];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(A_CMD): begin
        rd_mux[B_DST] = dis_st_o;
        rd_mux[B_DSF] = dis_sfns_o;
      end
      ADDR_W'(A_STAT):  rd_mux[3:0]    = state_i;
      ADDR_W'(A_LPCTL): rd_mux[B_ZDIS] = zdis_o;
      ADDR_W'(A_RET):   rd_mux         = ret_i;
      default:          rd_mux         = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_GO_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    req_o.go |-> $past(go_wr)); // R8
  AST_DST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dis_st_o |=> dis_st_o); // R9
  AST_DSF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dis_sfns_o |=> dis_sfns_o); // R9

endmodule

// File: rtl/sec_fsm.sv
module sec_fsm
  import sec_state_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  sec_req_t req_i,
  input  logic     dis_st_i,
  input  logic     dis_sfns_i,
  output sec_st_e  state_o,
  output logic     viol_evt_o
);

  sec_st_e state_nxt;

  assign state_nxt  = sec_next(state_o, req_i, dis_st_i, dis_sfns_i);
  assign viol_evt_o = sec_is_violation(req_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_o <= ST_CHECK;
    else        state_o <= state_nxt;
  end

  AST_NO_TRUST_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_SOFTFAIL || state_o == ST_NONSEC) |=> state_o != ST_TRUST); // R7
  AST_NONSEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == ST_NONSEC |=> state_o == ST_NONSEC); // R4
  AST_SEC2TR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_SECURE && dis_st_i && !viol_evt_o) |=> state_o == ST_SECURE); // R3
  AST_SF2NS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_SOFTFAIL && dis_sfns_i) |=> state_o == ST_SOFTFAIL); // R4
  AST_FATAL_SOFTFAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i.fatal && state_o != ST_NONSEC) |=> state_o == ST_SOFTFAIL); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |=> $stable(state_o)); // R8
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_o inside {ST_CHECK, ST_TRUST, ST_SECURE, ST_SOFTFAIL, ST_NONSEC}); // R1

endmodule

// File: rtl/sec_retention.sv
module sec_retention #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wipe_i,
  output logic [DATA_W-1:0] ret_o
);

  logic [DATA_W-1:0] bit_mask;
  assign bit_mask = DATA_W'(1) << idx_i;

  // Wipe outranks every bus write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ret_o <= '0;
    else if (wipe_i) ret_o <= '0;
    else if (we_i)   ret_o <= wdata_i;
    else if (set_i)  ret_o <= ret_o | bit_mask;
    else if (clr_i)  ret_o <= ret_o & ~bit_mask;
  end

  AST_WIPE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_i |=> ret_o == '0); // R11
  AST_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !wipe_i && !we_i) |=> ret_o[$past(idx_i)]); // R10
  AST_BIT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i && !wipe_i && !we_i) |=> !ret_o[$past(idx_i)]); // R10

endmodule

// File: rtl/sec_state_ctrl.sv
module sec_state_ctrl
  import sec_state_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              viol_i,
  input  logic              fatal_i,
  output logic [DATA_W-1:0] rdata,
  output logic [3:0]        state_o
);

  localparam int IDX_W = $clog2(DATA_W);

  sec_req_t          req;
  sec_st_e           state;
  logic              dis_st, dis_sfns, zdis;
  logic              ret_we, ret_set, ret_clr;
  logic [IDX_W-1:0]  ret_idx;
  logic [DATA_W-1:0] ret_wdata, ret_q;
  logic              viol_evt, wipe;

  assign wipe    = viol_evt && !zdis;
  assign state_o = state;

  sec_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .viol_i(viol_i), .fatal_i(fatal_i), .state_i(state),
    .ret_i(ret_q), .rdata(rdata), .req_o(req), .dis_st_o(dis_st),
    .dis_sfns_o(dis_sfns), .zdis_o(zdis), .ret_we_o(ret_we),
    .ret_set_o(ret_set), .ret_clr_o(ret_clr), .ret_idx_o(ret_idx),
    .ret_wdata_o(ret_wdata)
  );

  sec_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_i(req), .dis_st_i(dis_st),
    .dis_sfns_i(dis_sfns), .state_o(state), .viol_evt_o(viol_evt)
  );

  sec_retention #(.DATA_W(DATA_W)) u_ret (
    .clk(clk), .rst_n(rst_n), .we_i(ret_we), .set_i(ret_set),
    .clr_i(ret_clr), .idx_i(ret_idx), .wdata_i(ret_wdata), .wipe_i(wipe),
    .ret_o(ret_q)
  );

  AST_ZDIS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_evt && zdis && !ret_we && !ret_set && !ret_clr) |=> $stable(ret_q)); // R11

endmodule

// File: tb/sec_state_ctrl_tb.sv
module sec_state_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        viol_i = 1'b0, fatal_i = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  state_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  sec_state_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .viol_i(viol_i), .fatal_i(fatal_i), .rdata(rdata),
    .state_o(state_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pin(input bit v, input bit f);
    @(negedge clk); viol_i = v; fatal_i = f;
    @(negedge clk); viol_i = 1'b0; fatal_i = 1'b0;
  endtask

  // Expected state from the requirement text (codes 1..5)
  function automatic int model(int s, bit g, bit v, bit f, bit dst, bit dsf);
    if (s == 5) return 5;
    if (f) return 4;
    if (v) return (s == 1) ? 5 : 4;
    if (!g) return s;
    if (s == 1) return 2;
    if (s == 2) return 3;
    if (s == 3) return dst ? 3 : 2;
    return dsf ? 4 : 5;
  endfunction

  // Commands: 0 step,1 viol,2 fatal,3 viol pin,4 fatal pin,5 step+viol,6 viol+fatal,7 idle
  task automatic issue(input int k);
    case (k)
      0: wr(3'd0, 32'h1);
      1: wr(3'd0, 32'h2);
      2: wr(3'd0, 32'h4);
      3: pin(1'b1, 1'b0);
      4: pin(1'b0, 1'b1);
      5: wr(3'd0, 32'h3);
      6: wr(3'd0, 32'h6);
      default: repeat (2) @(negedge clk);
    endcase
  endtask

  function automatic string tag_for(int s, int k);
    if (k == 7) return "R8";
    if (k == 1 || k == 3) return "R5";
    if (k == 0) return (s == 3) ? "R3" : (s >= 4) ? "R4" : "R2";
    return "R6";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R1 reset state
    chk("R1 state pin", {28'd0, state_o}, 32'd1);
    rd(3'd1, d); chk("R1 status", d, 32'd1);
    rd(3'd0, d); chk("R1 disables", d, 32'd0);
    rd(3'd2, d); chk("R1 zdis", d, 32'd0);
    rd(3'd3, d); chk("R1 retention", d, 32'd0);

    // R12 one-edge delay, R8 one move per write
    wr(3'd0, 32'h1);
    chk("R12 before edge", {28'd0, state_o}, 32'd1);
    @(negedge clk);
    chk("R12 after edge", {28'd0, state_o}, 32'd2);
    repeat (5) @(negedge clk);
    chk("R8 single move", {28'd0, state_o}, 32'd2);
    rd(3'd0, d); chk("R8 cmd reads zero", d, 32'd0);

    // R10 retention access
    wr(3'd3, 32'h1234_5670);
    rd(3'd3, d); chk("R10 word", d, 32'h1234_5670);
    wr(3'd4, 32'd31);
    wr(3'd4, 32'd3);
    rd(3'd3, d); chk("R10 set", d, 32'h9234_5678);
    wr(3'd5, 32'd4);
    rd(3'd3, d); chk("R10 clear", d, 32'h9234_5668);
    rd(3'd4, d); chk("R10 set addr reads 0", d, 32'd0);
    rd(3'd7, d); chk("R10 unused addr reads 0", d, 32'd0);

    // R9 stickiness
    wr(3'd0, 32'h18);
    wr(3'd0, 32'h0);
    rd(3'd0, d); chk("R9 sticky", d, 32'h18);
    do_reset();
    rd(3'd0, d); chk("R9 reset clears", d, 32'd0);

    // Sweep: start state x disable config x command
    for (int s = 1; s <= 5; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int k = 0; k < 8; k++) begin
          bit dst, dsf, zd, v, f, g;
          logic [31:0] pat;
          int e;
          dst = c[0]; dsf = c[1]; zd = c[2];
          do_reset();
          if (dst || dsf) wr(3'd0, {27'd0, dsf, dst, 3'd0});
          wr(3'd2, {31'd0, zd});
          case (s)
            2: wr(3'd0, 32'h1);
            3: begin wr(3'd0, 32'h1); wr(3'd0, 32'h1); end
            4: begin wr(3'd0, 32'h1); wr(3'd0, 32'h2); end
            5: wr(3'd0, 32'h2);
            default: ;
          endcase
          pat = 32'hA5C3_0F96 ^ (s * 64 + c * 8 + k);
          wr(3'd3, pat);
          rd(3'd1, d); chk("R2 reach", d, s);
          issue(k);
          g = (k == 0 || k == 5);
          v = (k == 1 || k == 3 || k == 5 || k == 6);
          f = (k == 2 || k == 4 || k == 6);
          e = model(s, g, v, f, dst, dsf);
          rd(3'd1, d); chk(tag_for(s, k), d, e);
          chk(tag_for(s, k), {28'd0, state_o}, e);
          if (s >= 4) chk("R7 no trusted", {31'd0, state_o == 4'd2}, 32'd0);
          rd(3'd3, d); chk("R11 retention", d, ((v || f) && !zd) ? 32'd0 : pat);
          rd(3'd0, d); chk("R9 disables kept", d, {27'd0, dsf, dst, 3'd0});
        end
      end
    end

    // R7 chain from soft-fail: step then step tries never reach trusted
    do_reset();
    wr(3'd0, 32'h1); wr(3'd0, 32'h2);
    for (int i = 0; i < 4; i++) wr(3'd0, 32'h1);
    rd(3'd1, d); chk("R7 chain", d, 32'd5);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule